// File: doc/BRIEF.md
# Dual-Rail Line Jitter Attenuator Buffer

This block takes a recovered dual-rail line signal and removes the jitter on its clock and data. The signal arrives as a recovered clock with a positive-rail bit and a negative-rail bit. On each rising edge of the recovered clock, the two rail bits are written as one pair into a circular buffer. The pairs are read out in the order they were written, on a smooth output clock. That clock is made inside the block by dividing a fast reference clock, which runs at four times the nominal line rate, by four. Everything runs in the reference clock domain. The recovered clock is synchronised into that domain and treated as a write enable.

A small digital phase-locked loop compares the buffer fill level with half depth. In at most one of every sixteen output periods it shortens the division to three or lengthens it to five. Over the long term this makes the output rate follow the average input rate, while short-term phase wander is absorbed by the buffer.

The buffer depth is selectable: a deep setting for large wander and a shallow setting for lower delay. If the fill level drifts close to empty or to full, a buffer-limit flag is raised and the pointers are moved back to half depth. A bypass input sends the line clock and data straight to the outputs.

Top module: `dj_dejitter_buffer`

## Requirements
- R1: The line clock passes through a two-stage synchroniser. Each rising edge seen at the second stage gives a write strobe lasting one cycle. That strobe writes the rail pair sampled through the same two stages. A line clock held high writes only once.
- R2: With no trim, the output clock has a period of 4 reference cycles. It is high for the first 2 of them. The output rails (out_pos = stored positive bit, out_neg = stored negative bit) change only as out_clk rises, and pairs leave in the order they were written.
- R3: Only once every 16 output periods may the next period change. It becomes 3 cycles if the fill level is above half depth, 5 cycles if it is below, and stays 4 if it equals half depth. All other periods are 4 cycles.
- R4: depth_sel = 1 selects 128 entries and depth_sel = 0 selects 32 entries. The input is sampled only at reset and at a recentring. At other times a change of depth_sel has no effect.
- R5: When the fill level is 2 or less, or is the depth minus 2 or more, buf_limit goes high and stays high until reset. In the same cycle the read pointer is placed exactly half the depth behind the write pointer.
- R6: At the 128-entry depth, input phase wander of 75 unit intervals peak to peak with an unchanged average rate is absorbed without raising buf_limit.
- R7: While bypass = 1, out_clk, out_pos and out_neg equal line_clk, line_pos and line_neg combinationally.
- R8: Synchronous reset clears buf_limit, sets both output rails to 0 and out_clk to 1, clears the buffer contents and places the pointers half the depth apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock at four times the line rate |
| rst | input | 1 | Synchronous reset, active high |
| line_clk | input | 1 | Recovered line clock, asynchronous |
| line_pos | input | 1 | Positive-rail data bit |
| line_neg | input | 1 | Negative-rail data bit |
| depth_sel | input | 1 | 1 selects 128 entries, 0 selects 32 |
| bypass | input | 1 | 1 passes line signals straight through |
| out_clk | output | 1 | Smoothed output clock |
| out_pos | output | 1 | Positive-rail output bit |
| out_neg | output | 1 | Negative-rail output bit |
| buf_limit | output | 1 | Sticky flag set when the buffer neared empty or full |

## Verification
The assertions check several rules on every cycle. Write strobes are always single-cycle. The output clock rises right after each read. A trimmed period can occur only at the start of a new sixteen-period window. buf_limit never drops without a reset. Every recentring leaves the fill at exactly half depth, and the depth setting does not move unless a recentring happens. The bench's scenarios show the rest. The exact data order, and the tolerance to wander, need full sequences of input edges. So does the fact that the loop chooses 3 or 5 in the right direction, and the timing of limit events, which differs between the two depths.

// File: rtl/dj_pkg.sv
package dj_pkg;
    typedef logic [1:0] rail_pair_t;   // [1] positive rail, [0] negative rail

    localparam int unsigned DJ_DEPTH_BIG   = 128;
    localparam int unsigned DJ_DEPTH_SMALL = 32;
    localparam int unsigned DJ_MARGIN      = 2;
    localparam int unsigned DJ_NOM_DIV     = 4;
    localparam int unsigned DJ_ADJ_EVERY   = 16;
endpackage

// File: rtl/dj_line_sampler.sv
module dj_line_sampler
    import dj_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line_clk,
    input  rail_pair_t line_pair,
    output logic       wr_stb,
    output rail_pair_t wr_pair
);
    typedef struct packed {
        logic [2:0] ck;
        rail_pair_t p1;
        rail_pair_t p2;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d    = smp_q;
        smp_d.ck = {smp_q.ck[1:0], line_clk};
        smp_d.p1 = line_pair;
        smp_d.p2 = smp_q.p1;
        if (rst) smp_d = '0;
    end

    always_ff @(posedge clk) smp_q <= smp_d;

    assign wr_stb  = smp_q.ck[1] & ~smp_q.ck[2];
    assign wr_pair = smp_q.p2;

    assert_single_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/dj_rate_div.sv
module dj_rate_div #(
    parameter int unsigned DEPTH_BIG   = 128,
    parameter int unsigned DEPTH_SMALL = 32,
    parameter int unsigned NOM_DIV     = 4,
    parameter int unsigned ADJ_EVERY   = 16,
    parameter int unsigned PW          = $clog2(DEPTH_BIG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] fill,
    input  logic          depth_big,
    output logic          rd_stb,
    output logic          div_clk
);
    localparam int unsigned CW = $clog2(NOM_DIV + 2);
    localparam int unsigned GW = $clog2(ADJ_EVERY);
    localparam logic [CW-1:0] NOM  = CW'(NOM_DIV);
    localparam logic [CW-1:0] FAST = CW'(NOM_DIV - 1);
    localparam logic [CW-1:0] SLOW = CW'(NOM_DIV + 1);
    localparam logic [CW-1:0] HI   = CW'(NOM_DIV / 2);
    localparam logic [GW-1:0] LAST_GAP = GW'(ADJ_EVERY - 1);
    localparam logic [PW-1:0] HALF_B = PW'(DEPTH_BIG / 2);
    localparam logic [PW-1:0] HALF_S = PW'(DEPTH_SMALL / 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] per;
        logic [GW-1:0] gap;
    } div_t;

    div_t div_d, div_q;
    logic [PW-1:0] half_w;

    assign half_w  = depth_big ? HALF_B : HALF_S;
    assign rd_stb  = (div_q.cnt == div_q.per - CW'(1));
    assign div_clk = (div_q.cnt < HI);

    always_comb begin
        div_d = div_q;
        if (rd_stb) begin
            div_d.cnt = '0;
            div_d.gap = div_q.gap + GW'(1);
            div_d.per = NOM;
            if (div_q.gap == LAST_GAP) begin
                if (fill > half_w)      div_d.per = FAST;
                else if (fill < half_w) div_d.per = SLOW;
            end
        end else begin
            div_d.cnt = div_q.cnt + CW'(1);
        end
        if (rst) begin
            div_d     = '0;
            div_d.per = NOM;
        end
    end

    always_ff @(posedge clk) div_q <= div_d;

    assert_clk_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> $rose(div_clk));
    assert_one_trim_per_window_R3: assert property (@(posedge clk) disable iff (rst)
        (div_q.gap != '0) |-> (div_q.per == NOM));
    assert_trim_limits_R3: assert property (@(posedge clk) disable iff (rst)
        (div_q.per >= FAST) && (div_q.per <= SLOW));
endmodule

// File: rtl/dj_elastic_store.sv
module dj_elastic_store
    import dj_pkg::*;
#(
    parameter int unsigned DEPTH_BIG   = 128,
    parameter int unsigned DEPTH_SMALL = 32,
    parameter int unsigned MARGIN      = 2,
    parameter int unsigned PW          = $clog2(DEPTH_BIG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  rail_pair_t    wr_pair,
    input  logic          rd_stb,
    input  logic          depth_sel,
    output rail_pair_t    rd_pair,
    output logic [PW-1:0] fill,
    output logic          depth_big,
    output logic          limit_flag
);
    localparam logic [PW-1:0] MASK_B = PW'(DEPTH_BIG - 1);
    localparam logic [PW-1:0] MASK_S = PW'(DEPTH_SMALL - 1);
    localparam logic [PW-1:0] HALF_B = PW'(DEPTH_BIG / 2);
    localparam logic [PW-1:0] HALF_S = PW'(DEPTH_SMALL / 2);
    localparam logic [PW:0]   SIZE_B = (PW+1)'(DEPTH_BIG);
    localparam logic [PW:0]   SIZE_S = (PW+1)'(DEPTH_SMALL);
    localparam logic [PW:0]   MARG   = (PW+1)'(MARGIN);

    typedef struct packed {
        rail_pair_t [DEPTH_BIG-1:0] mem;
        logic [PW-1:0]              wr;
        logic [PW-1:0]              rd;
        logic                       big;
        rail_pair_t                 outp;
        logic                       flag;
    } st_t;

    st_t st_d, st_q;
    logic [PW-1:0] mask_w, half_w, fill_w, nmask_w, nhalf_w;
    logic [PW:0]   size_w;
    logic          hit_w;

    always_comb begin
        mask_w  = st_q.big ? MASK_B : MASK_S;
        half_w  = st_q.big ? HALF_B : HALF_S;
        size_w  = st_q.big ? SIZE_B : SIZE_S;
        nmask_w = depth_sel ? MASK_B : MASK_S;
        nhalf_w = depth_sel ? HALF_B : HALF_S;
        fill_w  = (st_q.wr - st_q.rd) & mask_w;
        hit_w   = ({1'b0, fill_w} <= MARG) || ({1'b0, fill_w} >= size_w - MARG);
    end

    always_comb begin
        st_d = st_q;
        if (rd_stb) begin
            st_d.outp = st_q.mem[st_q.rd];
            st_d.rd   = (st_q.rd + PW'(1)) & mask_w;
        end
        if (wr_stb) begin
            st_d.mem[st_q.wr] = wr_pair;
            st_d.wr           = (st_q.wr + PW'(1)) & mask_w;
        end
        if (hit_w) begin
            st_d.flag = 1'b1;
            st_d.big  = depth_sel;
            st_d.wr   = st_d.wr & nmask_w;
            st_d.rd   = (st_d.wr - nhalf_w) & nmask_w;
        end
        if (rst) begin
            st_d     = '0;
            st_d.big = depth_sel;
            st_d.rd  = nhalf_w;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign rd_pair    = st_q.outp;
    assign fill       = fill_w;
    assign depth_big  = st_q.big;
    assign limit_flag = st_q.flag;

    assert_recentre_half_R5: assert property (@(posedge clk) disable iff (rst)
        hit_w |=> (fill_w == half_w));
    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        st_q.flag |=> st_q.flag);
    assert_depth_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !hit_w |=> $stable(st_q.big));
endmodule

// File: rtl/dj_dejitter_buffer.sv
module dj_dejitter_buffer
    import dj_pkg::*;
#(
    parameter int unsigned DEPTH_BIG   = DJ_DEPTH_BIG,
    parameter int unsigned DEPTH_SMALL = DJ_DEPTH_SMALL,
    parameter int unsigned MARGIN      = DJ_MARGIN,
    parameter int unsigned NOM_DIV     = DJ_NOM_DIV,
    parameter int unsigned ADJ_EVERY   = DJ_ADJ_EVERY
) (
    input  logic clk,
    input  logic rst,
    input  logic line_clk,
    input  logic line_pos,
    input  logic line_neg,
    input  logic depth_sel,
    input  logic bypass,
    output logic out_clk,
    output logic out_pos,
    output logic out_neg,
    output logic buf_limit
);
    localparam int unsigned PW = $clog2(DEPTH_BIG);

    logic          wr_stb, rd_stb, div_clk, depth_big, limit_flag;
    rail_pair_t    wr_pair, rd_pair;
    logic [PW-1:0] fill;

    dj_line_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .line_clk  (line_clk),
        .line_pair ({line_pos, line_neg}),
        .wr_stb    (wr_stb),
        .wr_pair   (wr_pair)
    );

    dj_elastic_store #(
        .DEPTH_BIG   (DEPTH_BIG),
        .DEPTH_SMALL (DEPTH_SMALL),
        .MARGIN      (MARGIN),
        .PW          (PW)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .wr_pair    (wr_pair),
        .rd_stb     (rd_stb),
        .depth_sel  (depth_sel),
        .rd_pair    (rd_pair),
        .fill       (fill),
        .depth_big  (depth_big),
        .limit_flag (limit_flag)
    );

    dj_rate_div #(
        .DEPTH_BIG   (DEPTH_BIG),
        .DEPTH_SMALL (DEPTH_SMALL),
        .NOM_DIV     (NOM_DIV),
        .ADJ_EVERY   (ADJ_EVERY),
        .PW          (PW)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .fill      (fill),
        .depth_big (depth_big),
        .rd_stb    (rd_stb),
        .div_clk   (div_clk)
    );

    // R7: straight pass-through when bypassed
    assign out_clk   = bypass ? line_clk : div_clk;
    assign out_pos   = bypass ? line_pos : rd_pair[1];
    assign out_neg   = bypass ? line_neg : rd_pair[0];
    assign buf_limit = limit_flag;
endmodule

// File: tb/dj_dejitter_buffer_tb.sv
module dj_dejitter_buffer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_clk = 1'b0, line_pos = 1'b0, line_neg = 1'b0;
    logic depth_sel = 1'b1, bypass = 1'b0;
    logic out_clk, out_pos, out_neg, buf_limit;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    dj_dejitter_buffer u_dut (
        .clk(clk), .rst(rst), .line_clk(line_clk), .line_pos(line_pos),
        .line_neg(line_neg), .depth_sel(depth_sel), .bypass(bypass),
        .out_clk(out_clk), .out_pos(out_pos), .out_neg(out_neg),
        .buf_limit(buf_limit)
    );

    // ---------------- behavioural reference model ----------------
    int m_mem [0:127];
    int m_s1, m_s2, m_s3, m_d1, m_d2;
    int m_wr, m_rd, m_depth, m_cnt, m_per, m_gap, m_out, m_flag;
    bit armed = 0;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_d1 = 0; m_d2 = 0;
            m_depth = depth_sel ? 128 : 32;
            m_wr = 0; m_rd = m_depth / 2;
            m_cnt = 0; m_per = 4; m_gap = 0; m_out = 0; m_flag = 0;
            armed = 1;
        end else begin
            int fill, wr_n, rd_n;
            bit stb, rds;
            stb  = (m_s2 == 1) && (m_s3 == 0);
            rds  = (m_cnt == m_per - 1);
            fill = (m_wr - m_rd) & (m_depth - 1);
            wr_n = m_wr; rd_n = m_rd;
            if (rds) begin
                m_out = m_mem[m_rd];
                rd_n = (m_rd + 1) & (m_depth - 1);
                if (m_gap == 15) m_per = (fill > m_depth/2) ? 3 : (fill < m_depth/2) ? 5 : 4;
                else m_per = 4;
                m_gap = (m_gap + 1) % 16;
                m_cnt = 0;
            end else m_cnt = m_cnt + 1;
            if (stb) begin
                m_mem[m_wr] = m_d2;
                wr_n = (m_wr + 1) & (m_depth - 1);
            end
            if (fill <= 2 || fill >= m_depth - 2) begin
                m_flag = 1;
                m_depth = depth_sel ? 128 : 32;
                wr_n = wr_n & (m_depth - 1);
                rd_n = (wr_n - m_depth/2) & (m_depth - 1);
            end
            m_wr = wr_n; m_rd = rd_n;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(line_clk);
            m_d2 = m_d1; m_d1 = {30'd0, line_pos, line_neg};
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // ---------------- per-cycle comparison and period counting ----------------
    int cyc = 0, last_rise = 0, n3 = 0, n5 = 0;
    logic prev_oc = 1'b0;

    always @(posedge clk) begin
        #5;
        cyc++;
        if (armed) begin
            int e_clk, e_pos, e_neg;
            e_clk = bypass ? int'(line_clk) : int'(m_cnt < 2);
            e_pos = bypass ? int'(line_pos) : (m_out >> 1) & 1;
            e_neg = bypass ? int'(line_neg) : m_out & 1;
            chk(int'(out_clk) == e_clk, "R2/R3 out_clk", int'(out_clk), e_clk);
            chk(int'(out_pos) == e_pos, "R1/R2/R4 out_pos", int'(out_pos), e_pos);
            chk(int'(out_neg) == e_neg, "R1/R2/R4 out_neg", int'(out_neg), e_neg);
            chk(int'(buf_limit) == m_flag, "R5 buf_limit", int'(buf_limit), m_flag);
            if (!bypass && !rst && out_clk && !prev_oc) begin
                if (cyc - last_rise == 3) n3++;
                if (cyc - last_rise == 5) n5++;
                last_rise = cyc;
            end
            prev_oc = out_clk;
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input int per);
        int hi;
        hi = (per >= 4) ? 2 : 1;
        line_pos = 1'($urandom);
        line_neg = 1'($urandom);
        line_clk = 1'b1;
        repeat (hi) @(negedge clk);
        line_clk = 1'b0;
        repeat (per - hi) @(negedge clk);
    endtask

    task automatic do_reset(input logic sel);
        depth_sel = sel;
        line_clk = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int a3, a5;
        @(negedge clk);
        do_reset(1'b1);
        // R8: reset state
        chk(buf_limit == 1'b0, "R8 reset buf_limit", int'(buf_limit), 0);
        chk(out_pos == 1'b0 && out_neg == 1'b0, "R8 reset rails",
            int'({out_pos, out_neg}), 0);
        chk(out_clk == 1'b1, "R8 reset out_clk", int'(out_clk), 1);

        // R2: nominal rate
        repeat (300) send_bit(4);

        // R6: 75 UI peak-to-peak wander, average rate unchanged
        do_reset(1'b1);
        repeat (150) send_bit(5);
        for (int k = 0; k < 2; k++) begin
            repeat (300) send_bit(3);
            repeat (300) send_bit(5);
        end
        repeat (150) send_bit(3);
        chk(buf_limit == 1'b0, "R6 wander absorbed", int'(buf_limit), 0);

        // R3: slow input gives stretched periods
        do_reset(1'b1);
        a5 = n5;
        for (int k = 0; k < 300; k++) send_bit((k % 8 == 7) ? 5 : 4);
        chk(n5 > a5, "R3 period of 5 seen on slow input", n5 - a5, 1);

        // R3: fast input gives shortened periods
        do_reset(1'b1);
        a3 = n3;
        for (int k = 0; k < 400; k++) send_bit((k % 8 == 7) ? 3 : 4);
        chk(n3 > a3, "R3 period of 3 seen on fast input", n3 - a3, 1);

        // R4/R5: shallow depth overruns quickly; depth change waits for recentre
        do_reset(1'b0);
        repeat (133) send_bit(3);
        chk(buf_limit == 1'b1, "R4 shallow depth limit by 400 cycles", int'(buf_limit), 1);
        depth_sel = 1'b1;
        repeat (300) send_bit(3);

        // R4/R5: deep depth overruns only later
        do_reset(1'b1);
        repeat (133) send_bit(3);
        chk(buf_limit == 1'b0, "R4 deep depth no limit at 400 cycles", int'(buf_limit), 0);
        repeat (370) send_bit(3);
        chk(buf_limit == 1'b1, "R5 overrun limit", int'(buf_limit), 1);

        // R5/R1: stopped line clock underruns
        do_reset(1'b1);
        line_clk = 1'b1;
        repeat (400) @(negedge clk);
        line_clk = 1'b0;
        chk(buf_limit == 1'b1, "R5 underrun limit", int'(buf_limit), 1);

        // R7: bypass pass-through
        bypass = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            {line_clk, line_pos, line_neg} = 3'(k);
            #1;
            chk({out_clk, out_pos, out_neg} == 3'(k), "R7 bypass",
                int'({out_clk, out_pos, out_neg}), k);
        end
        bypass = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule